// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block connects two parallel data buses, called side A and side B. It can move data in one direction at a time, or it can isolate both buses. Each bus has separate input, output and output-enable ports, so the core needs no tri-state logic. The pad ring or the surrounding fabric merges each triple into a real bus.

Two storage registers hold a snapshot of each bus. The A register samples the A input on a rising edge of its own clock. The B register samples the B input on a rising edge of a second clock. Sampling happens on every rising edge, whatever the enable and direction controls are doing, so a bus can be stored while both outputs are off.

An active-low enable and a direction input choose the driven bus. Each direction has its own source select. The select passes either the live data arriving from the opposite bus or the content of that bus's storage register. All routing is combinational, so a control or data change reaches the outputs in the same cycle.

Top module: `xb_regxcvr`

## Requirements
- R1: With `en_n`=0 and `dir`=0, `a_oe`=1 and `b_oe`=0, and `a_out` carries B-side data.
- R2: With `en_n`=0 and `dir`=1, `b_oe`=1 and `a_oe`=0, and `b_out` carries A-side data.
- R3: With `en_n`=1, both `a_oe` and `b_oe` are 0 and both `a_out` and `b_out` are all zeros. Any data output whose enable is 0 reads all zeros.
- R4: `a_oe` and `b_oe` are never 1 at the same time, for any combination of `en_n` and `dir`.
- R5: The A register loads `a_in` on each rising edge of `clk_ab` while `rst_n`=1.
- R6: The B register loads `b_in` on each rising edge of `clk_ba` while `rst_n`=1.
- R7: Both registers load on their clock edges whatever `en_n`, `dir` and the selects are, including while the block is isolated.
- R8: A select of 0 passes live data. For `sel_ab`=0, `b_out` equals `a_in`. For `sel_ba`=0, `a_out` equals `b_in`.
- R9: A select of 1 passes stored data. For `sel_ab`=1, `b_out` equals the A register. For `sel_ba`=1, `a_out` equals the B register.
- R10: When `rst_n`=0 at a rising edge of a register's clock, that register clears to zero. Reset takes priority over a load.
- R11: Output enables and data outputs respond combinationally to `en_n`, `dir`, the selects and the bus inputs, with no clock edge needed.
- R12: `sel_ab` has no effect on `a_out`, and `sel_ba` has no effect on `b_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Load clock of the A storage register |
| clk_ba | input | 1 | Load clock of the B storage register |
| rst_n | input | 1 | Active-low synchronous reset of both registers |
| en_n | input | 1 | Active-low transfer enable; 1 isolates both buses |
| dir | input | 1 | 0 drives the A bus, 1 drives the B bus |
| sel_ab | input | 1 | B-bus source: 0 live A input, 1 stored A register |
| sel_ba | input | 1 | A-bus source: 0 live B input, 1 stored B register |
| a_in | input | 8 | Data received from the A bus |
| a_out | output | 8 | Data to drive onto the A bus |
| a_oe | output | 1 | Drive enable of the A bus |
| b_in | input | 8 | Data received from the B bus |
| b_out | output | 8 | Data to drive onto the B bus |
| b_oe | output | 1 | Drive enable of the B bus |

## Verification
Routing results are due with zero latency. The bench changes a control or bus input and samples the outputs one time step later, with no clock edge in between. Register contents become visible after exactly one rising edge of their own clock. Each vector therefore applies its inputs, gives the selected clocks a single full pulse, and samples after the falling half with a stored-data select set. Reset is checked the same way, one edge after `rst_n` is pulled low.

// File: rtl/xb_pkg.sv
package xb_pkg;

  typedef enum logic [1:0] {
    ROUTE_NONE = 2'b00,
    ROUTE_TO_A = 2'b01,
    ROUTE_TO_B = 2'b10
  } route_e;

  function automatic route_e route_of(input logic en_n, input logic dir);
    if (en_n)
      return ROUTE_NONE;
    return dir ? ROUTE_TO_B : ROUTE_TO_A;
  endfunction

endpackage

// File: rtl/xb_cap_reg.sv
module xb_cap_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      q <= '0;
    else
      q <= d;
  end

  // Covers R5 for the A register and R6 for the B register
  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (q == $past(d)));

endmodule

// File: rtl/xb_route_dec.sv
module xb_route_dec
  import xb_pkg::*;
(
  input  logic en_n,
  input  logic dir,
  output logic drive_a,
  output logic drive_b
);

  route_e route;

  always_comb begin
    route   = route_of(en_n, dir);
    drive_a = (route == ROUTE_TO_A);
    drive_b = (route == ROUTE_TO_B);
  end

endmodule

// File: rtl/xb_src_mux.sv
module xb_src_mux #(
  parameter int W = 8
) (
  input  logic         drive,
  input  logic         sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] y
);

  always_comb begin
    if (!drive)
      y = '0;
    else if (sel)
      y = stored;
    else
      y = live;
  end

endmodule

// File: rtl/xb_regxcvr.sv
module xb_regxcvr #(
  parameter int DATA_W = 8
) (
  input  logic              clk_ab,
  input  logic              clk_ba,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              dir,
  input  logic              sel_ab,
  input  logic              sel_ba,
  input  logic [DATA_W-1:0] a_in,
  output logic [DATA_W-1:0] a_out,
  output logic              a_oe,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] b_out,
  output logic              b_oe
);

  localparam int NPATH = 2;

  logic [DATA_W-1:0] held_a;
  logic [DATA_W-1:0] held_b;
  logic              drive_a;
  logic              drive_b;

  logic [NPATH-1:0]             p_clk;
  logic [NPATH-1:0][DATA_W-1:0] p_din;
  logic [NPATH-1:0][DATA_W-1:0] p_hold;

  assign p_clk = {clk_ba, clk_ab};
  assign p_din = {b_in, a_in};

  generate
    for (genvar i = 0; i < NPATH; i++) begin : g_store
      xb_cap_reg #(.W(DATA_W)) u_reg (
        .clk   (p_clk[i]),
        .rst_n (rst_n),
        .d     (p_din[i]),
        .q     (p_hold[i])
      );
    end
  endgenerate

  assign held_a = p_hold[0];
  assign held_b = p_hold[1];

  xb_route_dec u_dec (
    .en_n    (en_n),
    .dir     (dir),
    .drive_a (drive_a),
    .drive_b (drive_b)
  );

  xb_src_mux #(.W(DATA_W)) u_mux_to_a (
    .drive  (drive_a),
    .sel    (sel_ba),
    .live   (b_in),
    .stored (held_b),
    .y      (a_out)
  );

  xb_src_mux #(.W(DATA_W)) u_mux_to_b (
    .drive  (drive_b),
    .sel    (sel_ab),
    .live   (a_in),
    .stored (held_a),
    .y      (b_out)
  );

  assign a_oe = drive_a;
  assign b_oe = drive_b;

  p_one_bus_r4: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !(a_oe && b_oe));

  p_isolate_r3: assert property (@(posedge clk_ab) disable iff (!rst_n)
    en_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));

  p_live_ab_r8: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!en_n && dir && !sel_ab) |-> (b_out == a_in));

  p_stored_ba_r9: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (!en_n && !dir && sel_ba) |-> (a_out == held_b));

  p_to_a_r1: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (!en_n && !dir) |-> (a_oe && !b_oe));

endmodule

// File: tb/sim_xb_regxcvr.sv
module sim_xb_regxcvr;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  // {en_n,dir,sel_ab,sel_ba,pulse_ab,pulse_ba,exp_a_oe,exp_b_oe}, a_in, b_in, exp_a_out, exp_b_out
  localparam logic [39:0] VEC [NVEC] = '{
    {8'b1000_1100, 8'h11, 8'h22, 8'h00, 8'h00}, // R3 R7 store while isolated
    {8'b0000_0010, 8'h33, 8'h44, 8'h44, 8'h00}, // R1 R8
    {8'b0001_0010, 8'h33, 8'h44, 8'h22, 8'h00}, // R1 R9
    {8'b0100_0001, 8'h55, 8'h66, 8'h00, 8'h55}, // R2 R8
    {8'b0110_0001, 8'h55, 8'h66, 8'h00, 8'h11}, // R2 R9
    {8'b0111_1001, 8'h77, 8'h88, 8'h00, 8'h77}, // R5 R9
    {8'b0011_0110, 8'h99, 8'hAA, 8'hAA, 8'h00}, // R6 R12
    {8'b1111_1100, 8'hC3, 8'h3C, 8'h00, 8'h00}, // R7 R3
    {8'b0001_0010, 8'h00, 8'hFF, 8'h3C, 8'h00}, // R7 R9
    {8'b0110_0001, 8'h00, 8'hFF, 8'h00, 8'hC3}  // R7 R9
  };

  logic       clk_ab = 1'b0, clk_ba = 1'b0, rst_n = 1'b0;
  logic       en_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [7:0] a_in = '0, b_in = '0;
  logic [7:0] a_out, b_out;
  logic       a_oe, b_oe;

  int total = 0;
  int bad = 0;

  xb_regxcvr #(.DATA_W(8)) u0 (
    .clk_ab (clk_ab), .clk_ba (clk_ba), .rst_n (rst_n),
    .en_n (en_n), .dir (dir), .sel_ab (sel_ab), .sel_ba (sel_ba),
    .a_in (a_in), .a_out (a_out), .a_oe (a_oe),
    .b_in (b_in), .b_out (b_out), .b_oe (b_oe)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pulse(input logic pab, input logic pba);
    #1;
    clk_ab = pab;
    clk_ba = pba;
    #(CLK_PERIOD / 2);
    clk_ab = 1'b0;
    clk_ba = 1'b0;
    #(CLK_PERIOD / 2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R10: reset wins over a load
    a_in = 8'hA5; b_in = 8'h5A;
    pulse(1'b1, 1'b1);
    pulse(1'b1, 1'b1);
    rst_n = 1'b1;
    en_n = 1'b0; dir = 1'b0; sel_ba = 1'b1;
    #1 check("R10 A bus stored B after reset", {8'h0, a_out}, 16'h0000);
    dir = 1'b1; sel_ab = 1'b1;
    #1 check("R10 B bus stored A after reset", {8'h0, b_out}, 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      logic [39:0] v;
      v = VEC[i];
      en_n = v[39]; dir = v[38]; sel_ab = v[37]; sel_ba = v[36];
      a_in = v[31:24]; b_in = v[23:16];
      pulse(v[35], v[34]);
      check(v[39] ? "R3 vector enables" : (v[38] ? "R2 vector enables" : "R1 vector enables"),
            {14'h0, a_oe, b_oe}, {14'h0, v[33], v[32]});
      check((v[38] ? v[37] : v[36]) ? "R9 vector data" : "R8 vector data",
            {a_out, b_out}, v[15:0]);
    end

    // R4: all four control combinations
    for (int c = 0; c < 4; c++) begin
      en_n = c[1]; dir = c[0];
      #1 check("R4 never both driven", {15'h0, a_oe & b_oe}, 16'h0000);
    end

    // R11: live data follows with no clock
    en_n = 1'b0; dir = 1'b1; sel_ab = 1'b0;
    a_in = 8'h6E;
    #1 check("R11 B bus follows a_in", {8'h0, b_out}, 16'h006E);
    a_in = 8'h19;
    #1 check("R11 B bus follows a_in change", {8'h0, b_out}, 16'h0019);
    en_n = 1'b1;
    #1 check("R11 enable off without clock", {14'h0, a_oe, b_oe}, 16'h0000);

    // R12: sel_ab toggling leaves A bus alone (regs A=C3, B=3C)
    en_n = 1'b0; dir = 1'b0; sel_ba = 1'b0; b_in = 8'h42;
    sel_ab = 1'b0;
    #1 check("R12 A bus with sel_ab 0", {8'h0, a_out}, 16'h0042);
    sel_ab = 1'b1;
    #1 check("R12 A bus with sel_ab 1", {8'h0, a_out}, 16'h0042);

    // R10: reset again with registers holding data
    rst_n = 1'b0;
    pulse(1'b1, 1'b0);
    rst_n = 1'b1;
    dir = 1'b1; sel_ab = 1'b1;
    #1 check("R10 A register cleared", {8'h0, b_out}, 16'h0000);
    dir = 1'b0; sel_ba = 1'b1;
    #1 check("R6 B register untouched without its clock", {8'h0, a_out}, 16'h003C);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule